// File: doc/BRIEF.md
# Downward-Growing Operand Stack Unit

This block is a zero-address operand stack for a small datapath. Operands live in an internal register file indexed by a stack pointer. The stack fills from the highest slot toward slot zero. A command port takes one command per cycle, each with a valid/ready handshake, an opcode and a data word. The commands are push, pop and two arithmetic operations. The arithmetic operations name no operands. They consume the two entries at the top of the stack and leave the result in place of them.

The current top of the stack is always visible on a registered output. An illegal command leaves the stack untouched and instead raises one of two flags for one cycle. An illegal command is a push onto a full stack, or a removal that needs more entries than the stack holds. The depth, the data width and the adder structure are parameters.

Top module: `opstack_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `tos_data` is 0 and both flags are low. The stack is empty, meaning the pointer holds one past the highest slot. `cmd_ready` is low during reset.
- R2: An accepted push (`cmd_op` = 1) on a non-full stack moves the pointer down one slot and stores `cmd_data` there. `tos_data` shows `cmd_data` in the next cycle.
- R3: A push on a stack holding DEPTH entries sets `overflow` for the next cycle. It leaves `tos_data` and the stored entries unchanged.
- R4: An accepted pop (`cmd_op` = 2) on a non-empty stack moves the pointer up one slot. `tos_data` then shows the entry that was second from the top, or 0 if the stack became empty.
- R5: A pop on an empty stack sets `underflow` for the next cycle and changes nothing else.
- R6: An add (`cmd_op` = 3) with at least two entries replaces the top two entries with their sum modulo 2^DATA_W. Depth falls by one and `tos_data` shows the sum.
- R7: A subtract (`cmd_op` = 4) with at least two entries replaces the top two entries with (second from top) minus (top), modulo 2^DATA_W. Depth falls by one.
- R8: An add or subtract with fewer than two entries sets `underflow` for the next cycle and leaves the stack and `tos_data` unchanged.
- R9: A cycle with `cmd_valid` low, or with an opcode of 0, 5, 6 or 7, changes nothing. Both flags are low in the following cycle.
- R10: `cmd_ready` is high in every cycle after reset, and every command takes effect in the cycle it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle |
| cmd_op | input | 3 | Opcode: 0 none, 1 push, 2 pop, 3 add, 4 subtract |
| cmd_data | input | DATA_W | Word stored by a push |
| tos_data | output | DATA_W | Registered top entry, 0 when empty |
| overflow | output | 1 | Previous command was a push onto a full stack |
| underflow | output | 1 | Previous command needed more entries than held |

## Verification
An arithmetic command reads the second entry and writes its result into that same slot in the same cycle. In that same cycle the pointer also moves. The bench drives add and subtract commands when exactly two entries are held, and again when the stack is full. It then pops down to the bottom, so every slot written by a result is read back. A behavioural queue model predicts `tos_data` and both flags after every edge, including the cycle in which a boundary violation and a held top entry must appear together.

// File: rtl/opstack_pkg.sv
package opstack_pkg;
   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP  = 3'd0,
      OP_PUSH = 3'd1,
      OP_POP  = 3'd2,
      OP_ADD  = 3'd3,
      OP_SUB  = 3'd4
   } opcode_t;

   function automatic int ptr_width(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/opstack_store.sv
module opstack_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   parameter int SP_W   = 4
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [SP_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SP_W-1:0]   rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [SP_W-1:0]   rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b
);
   logic [DATA_W-1:0] slot [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == SP_W'(i)))
            slot[i] <= wr_data;
      end
   end

   // Reads outside the array return zero, which gives the empty-stack value.
   always_comb begin
      rd_data_a = '0;
      rd_data_b = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (rd_addr_a == SP_W'(k)) rd_data_a = slot[k];
         if (rd_addr_b == SP_W'(k)) rd_data_b = slot[k];
      end
   end
endmodule

// File: rtl/opstack_alu.sv
module opstack_alu #(
   parameter int DATA_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              do_sub,
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic [DATA_W-1:0] result
);
   if (SHARED_ADDER) begin : g_shared
      logic [DATA_W-1:0] rhs_eff;
      always_comb begin
         rhs_eff = do_sub ? ~rhs : rhs;
         result  = lhs + rhs_eff + DATA_W'(do_sub);
      end
   end else begin : g_split
      logic [DATA_W-1:0] sum_v, dif_v;
      always_comb begin
         sum_v  = lhs + rhs;
         dif_v  = lhs - rhs;
         result = do_sub ? dif_v : sum_v;
      end
   end
endmodule

// File: rtl/opstack_ctrl.sv
module opstack_ctrl
   import opstack_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   parameter int SP_W   = 4
) (
   input  logic              cmd_fire,
   input  logic [OPC_W-1:0]  cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic [SP_W-1:0]   sp_q,
   input  logic [DATA_W-1:0] tos_q,
   input  logic [DATA_W-1:0] second_val,
   input  logic [DATA_W-1:0] alu_res,
   output logic              alu_sub,
   output logic [SP_W-1:0]   sp_nxt,
   output logic              wr_en,
   output logic [SP_W-1:0]   wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] tos_nxt,
   output logic              ovf_nxt,
   output logic              udf_nxt
);
   localparam logic [SP_W-1:0] SP_EMPTY = SP_W'(DEPTH);
   localparam logic [SP_W-1:0] SP_PAIR  = SP_W'(DEPTH - 2);

   logic is_full, is_empty, has_pair;
   logic [SP_W-1:0] sp_up, sp_dn;

   always_comb begin
      is_full  = (sp_q == '0);
      is_empty = (sp_q == SP_EMPTY);
      has_pair = (sp_q <= SP_PAIR);
      sp_up    = sp_q + SP_W'(1);
      sp_dn    = sp_q - SP_W'(1);

      alu_sub  = 1'b0;
      sp_nxt   = sp_q;
      wr_en    = 1'b0;
      wr_addr  = sp_dn;
      wr_data  = cmd_data;
      tos_nxt  = tos_q;
      ovf_nxt  = 1'b0;
      udf_nxt  = 1'b0;

      if (cmd_fire) begin
         unique case (cmd_op)
            OP_PUSH: begin
               if (is_full) begin
                  ovf_nxt = 1'b1;
               end else begin
                  sp_nxt  = sp_dn;
                  wr_en   = 1'b1;
                  tos_nxt = cmd_data;
               end
            end
            OP_POP: begin
               if (is_empty) begin
                  udf_nxt = 1'b1;
               end else begin
                  sp_nxt  = sp_up;
                  tos_nxt = second_val;
               end
            end
            OP_ADD, OP_SUB: begin
               alu_sub = (cmd_op == OP_SUB);
               if (!has_pair) begin
                  udf_nxt = 1'b1;
               end else begin
                  sp_nxt  = sp_up;
                  wr_en   = 1'b1;
                  wr_addr = sp_up;
                  wr_data = alu_res;
                  tos_nxt = alu_res;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/opstack_unit.sv
module opstack_unit
   import opstack_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int DEPTH        = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   output logic [DATA_W-1:0] tos_data,
   output logic              overflow,
   output logic              underflow
);
   localparam int SP_W = ptr_width(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("opstack_unit: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("opstack_unit: DATA_W must be positive");
   end

   logic [SP_W-1:0]   sp_q, sp_nxt, wr_addr;
   logic [DATA_W-1:0] tos_q, tos_nxt, wr_data;
   logic [DATA_W-1:0] top_val, second_val, alu_res;
   logic              wr_en, alu_sub, ovf_nxt, udf_nxt;
   logic              ovf_q, udf_q, ready_q, cmd_fire;
   logic [SP_W-1:0]   sp_second;

   assign cmd_fire  = cmd_valid && ready_q;
   assign sp_second = sp_q + SP_W'(1);

   opstack_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SP_W(SP_W)) u_store (
      .clk       (clk),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr_a (sp_q),
      .rd_data_a (top_val),
      .rd_addr_b (sp_second),
      .rd_data_b (second_val)
   );

   opstack_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .do_sub (alu_sub),
      .lhs    (second_val),
      .rhs    (top_val),
      .result (alu_res)
   );

   opstack_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SP_W(SP_W)) u_ctrl (
      .cmd_fire   (cmd_fire),
      .cmd_op     (cmd_op),
      .cmd_data   (cmd_data),
      .sp_q       (sp_q),
      .tos_q      (tos_q),
      .second_val (second_val),
      .alu_res    (alu_res),
      .alu_sub    (alu_sub),
      .sp_nxt     (sp_nxt),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .tos_nxt    (tos_nxt),
      .ovf_nxt    (ovf_nxt),
      .udf_nxt    (udf_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q    <= SP_W'(DEPTH);
         tos_q   <= '0;
         ovf_q   <= 1'b0;
         udf_q   <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         sp_q    <= sp_nxt;
         tos_q   <= tos_nxt;
         ovf_q   <= ovf_nxt;
         udf_q   <= udf_nxt;
         ready_q <= 1'b1;
      end
   end

   assign cmd_ready = ready_q;
   assign tos_data  = tos_q;
   assign overflow  = ovf_q;
   assign underflow = udf_q;
endmodule

// File: rtl/opstack_checker.sv
module opstack_checker #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   parameter int SP_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [2:0]        cmd_op,
   input logic [DATA_W-1:0] cmd_data,
   input logic [DATA_W-1:0] tos_data,
   input logic              overflow,
   input logic              underflow,
   input logic [SP_W-1:0]   sp_q
);
   logic fire;
   assign fire = cmd_valid && cmd_ready;

   AST_PUSH_TOS: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cmd_op == 3'd1 && sp_q != '0 |=> tos_data == $past(cmd_data)); // R2
   AST_NO_OVERFLOW_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cmd_op == 3'd1 && sp_q == '0 |=> overflow && $stable(tos_data) && $stable(sp_q)); // R3
   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cmd_op == 3'd2 && sp_q == SP_W'(DEPTH) |=> underflow && $stable(sp_q)); // R5
   AST_ARITH_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      fire && (cmd_op == 3'd3 || cmd_op == 3'd4) && sp_q <= SP_W'(DEPTH - 2)
      |=> sp_q == $past(sp_q) + SP_W'(1)); // R6
   AST_ARITH_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      fire && (cmd_op == 3'd3 || cmd_op == 3'd4) && sp_q > SP_W'(DEPTH - 2)
      |=> underflow && $stable(tos_data)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !overflow && !underflow && $stable(tos_data)); // R9
   AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      sp_q <= SP_W'(DEPTH)); // R1
endmodule

bind opstack_unit opstack_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SP_W(SP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .cmd_data  (cmd_data),
   .tos_data  (tos_data),
   .overflow  (overflow),
   .underflow (underflow),
   .sp_q      (sp_q)
);

// File: tb/opstack_unit_test.sv
module opstack_unit_test;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic [2:0]        cmd_op = 3'd0;
   logic [DATA_W-1:0] cmd_data = '0;
   logic [DATA_W-1:0] tos_data;
   logic              overflow, underflow;

   int checks = 0;
   int fails  = 0;

   logic [DATA_W-1:0] model[$];
   logic [DATA_W-1:0] exp_tos = '0;
   logic              exp_ovf = 1'b0;
   logic              exp_udf = 1'b0;

   always #2 clk = ~clk;

   opstack_unit #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_data(cmd_data), .tos_data(tos_data),
      .overflow(overflow), .underflow(underflow)
   );

   task automatic check(input string req, input string what, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic v, input logic [2:0] op, input int n);
      if (!v) return "R9";
      case (op)
         3'd1: return (n == DEPTH) ? "R3" : "R2";
         3'd2: return (n == 0) ? "R5" : "R4";
         3'd3: return (n < 2) ? "R8" : "R6";
         3'd4: return (n < 2) ? "R8" : "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic model_step(input logic v, input logic [2:0] op, input logic [DATA_W-1:0] d);
      logic [DATA_W-1:0] a, b;
      exp_ovf = 1'b0;
      exp_udf = 1'b0;
      if (v) begin
         case (op)
            3'd1: if (model.size() == DEPTH) exp_ovf = 1'b1; else model.push_front(d);
            3'd2: if (model.size() == 0) exp_udf = 1'b1; else void'(model.pop_front());
            3'd3, 3'd4: begin
               if (model.size() < 2) exp_udf = 1'b1;
               else begin
                  b = model.pop_front();
                  a = model.pop_front();
                  model.push_front(op == 3'd3 ? a + b : a - b);
               end
            end
            default: ;
         endcase
      end
      exp_tos = (model.size() == 0) ? '0 : model[0];
   endtask

   task automatic step(input logic v, input logic [2:0] op, input logic [DATA_W-1:0] d);
      string req;
      @(negedge clk);
      cmd_valid = v;
      cmd_op    = op;
      cmd_data  = d;
      req = tag_of(v, op, model.size());
      @(posedge clk);
      model_step(v, op, d);
      #1;
      check(req, "tos_data", tos_data, exp_tos);
      check(req, "overflow", DATA_W'(overflow), DATA_W'(exp_ovf));
      check(req, "underflow", DATA_W'(underflow), DATA_W'(exp_udf));
      check("R10", "cmd_ready", DATA_W'(cmd_ready), DATA_W'(1));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset values
      check("R1", "tos_data in reset", tos_data, '0);
      check("R1", "overflow in reset", DATA_W'(overflow), '0);
      check("R1", "underflow in reset", DATA_W'(underflow), '0);
      check("R1", "cmd_ready in reset", DATA_W'(cmd_ready), '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1", "tos_data after reset", tos_data, '0);
      check("R1", "flags after reset", DATA_W'({overflow, underflow}), '0);

      step(1'b1, 3'd2, '0);                 // R5 pop on empty
      step(1'b1, 3'd3, '0);                 // R8 add on empty
      step(1'b1, 3'd1, 16'h0005);           // R2
      step(1'b1, 3'd4, '0);                 // R8 sub with one entry
      step(1'b1, 3'd1, 16'h0003);
      step(1'b1, 3'd4, '0);                 // R7 5-3 with exactly two entries
      step(1'b1, 3'd1, 16'h0009);
      step(1'b1, 3'd4, '0);                 // R7 2-9 wraps
      step(1'b1, 3'd2, '0);                 // R4 pop to empty
      for (int i = 0; i < DEPTH; i++) step(1'b1, 3'd1, DATA_W'(16'hFFF0 + i)); // R2 fill
      step(1'b1, 3'd1, 16'hABCD);           // R3 overflow
      step(1'b1, 3'd1, 16'h1234);           // R3 again
      step(1'b0, 3'd1, 16'h7777);           // R9 valid low
      step(1'b1, 3'd7, 16'h7777);           // R9 undefined opcode
      step(1'b1, 3'd0, 16'h7777);           // R9 nop
      step(1'b1, 3'd3, '0);                 // R6 add on full stack, wraps
      step(1'b1, 3'd4, '0);                 // R7
      for (int i = 0; i < DEPTH; i++) step(1'b1, 3'd2, '0); // R4 drain then R5
      for (int i = 0; i < 400; i++) begin
         logic [2:0] op;
         op = 3'($urandom_range(0, 7));
         if (op > 3'd4 && ($urandom_range(0, 1) == 0)) op = 3'd1;
         step(($urandom_range(0, 9) != 0), op, DATA_W'($urandom));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule